// File: doc/BRIEF.md
# CEC Frame Receiver

This block takes in frames from the single-wire, open-drain consumer-electronics control line. It times the pulses on the line against a slow bit tick. The tick comes from dividing the system clock by a programmable count. All pulse-width limits are inputs given in ticks, so the same logic serves any system clock. A start bit opens a frame. Each following bit is decoded from how long the line stays low. Every byte is ten bits on the wire: eight data bits sent most significant first, then an end-of-message bit, then an acknowledge slot.

The first sixteen bytes of a frame go into a byte buffer. The host reads that buffer as four little-endian 32-bit words. When the low nibble of the header matches the block's own logical address, the block pulls the line low in the acknowledge slot of every byte. Bytes past the sixteenth are still acknowledged but are not kept.

When a frame completes or aborts, the block sets an end flag and a status flag, and it pulses an interrupt. It then ignores the line until the host pulses a release input.

Top module: `cec_frame_receiver`

## Requirements
- R1: A bit tick occurs once every `div_count`+1 system clocks, and all pulse timing is counted in these ticks.
- R2: A frame opens only on a low pulse whose low time lies in [`thr_start_lo_min`, `thr_start_lo_max`] and whose fall-to-fall period lies in [`thr_start_per_min`, `thr_start_per_max`]. Any other low pulse on an idle line leaves `rx_eom` at 0 and raises no interrupt.
- R3: A low time in [`thr_one_min`, `thr_one_max`] decodes as 1, and one in [`thr_zero_min`, `thr_zero_max`] decodes as 0. The first bit of a byte is its bit 7.
- R4: Byte j of the frame (j < 16) appears on `rx_words[8*j+7 : 8*j]`, so byte 0 is the low byte of word 0.
- R5: `rx_len_m1` equals the number of stored bytes minus one, and saturates at 15.
- R6: A frame completes at the rise of the acknowledge slot of a byte whose end-of-message bit is 1. At that point `rx_eom` and `rx_good` go to 1 and `rx_irq` is high for exactly one clock.
- R7: A low time in neither decode window, or a bit period outside [`thr_bit_per_min`, `thr_bit_per_max`] (including the line staying high or low past the upper limit), aborts the frame. The abort sets `rx_eom`=1 with `rx_good`=0 and pulses `rx_irq`.
- R8: While `rx_eom` is 1, line activity is ignored: no acknowledge, no buffer write, no interrupt. A one-clock pulse on `rx_release` clears `rx_eom` and `rx_good` and re-arms reception. After reset all outputs are 0.
- R9: When the header's low nibble (the destination) equals `own_addr`, `line_pull` is 1 in each acknowledge slot, from the falling edge until `thr_ack_low` ticks have passed. It is 0 in data and end-of-message bits.
- R10: Destination 15 is broadcast and is never acknowledged, so an `own_addr` of 15 (unregistered) acknowledges nothing. Frames for another address are not acknowledged either.
- R11: In frames longer than 16 bytes, the later bytes are acknowledged but not stored, and the first 16 bytes remain in the buffer.
- R12: Low glitches shorter than `FILT_CYC` system clocks on the line are filtered out and do not disturb decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cec_in | input | 1 | Sampled level of the open-drain line |
| line_pull | output | 1 | 1 pulls the line low (acknowledge) |
| div_count | input | 12 | Tick divider; tick period is div_count+1 clocks |
| own_addr | input | 4 | Own logical address, 15 = unregistered |
| thr_start_lo_min | input | 8 | Start bit minimum low time, ticks |
| thr_start_lo_max | input | 8 | Start bit maximum low time, ticks |
| thr_start_per_min | input | 8 | Start bit minimum period, ticks |
| thr_start_per_max | input | 8 | Start bit maximum period, ticks |
| thr_one_min | input | 8 | Logic-1 minimum low time, ticks |
| thr_one_max | input | 8 | Logic-1 maximum low time, ticks |
| thr_zero_min | input | 8 | Logic-0 minimum low time, ticks |
| thr_zero_max | input | 8 | Logic-0 maximum low time, ticks |
| thr_bit_per_min | input | 8 | Data bit minimum period, ticks |
| thr_bit_per_max | input | 8 | Data bit maximum period, ticks |
| thr_ack_low | input | 8 | Acknowledge pull duration, ticks |
| rx_release | input | 1 | Pulse to leave the hold state |
| rx_eom | output | 1 | Frame ended (held until release) |
| rx_good | output | 1 | Frame ended without error |
| rx_irq | output | 1 | One-clock interrupt pulse at frame end |
| rx_len_m1 | output | 4 | Stored byte count minus one |
| rx_words | output | 128 | Four 32-bit data words, little-endian bytes |

## Verification
In the acknowledge slot of an own-addressed frame, two functions act on the same edge: the receiver's own pull stretches the low time, and the rise that ends that pull is also the edge that decodes the slot and can complete the frame. The bench makes this happen by sending frames to the block's address with every acknowledge slot driven as a short 1. It samples `line_pull` in the middle of the slot and then checks that the frame ends good with a single interrupt. A second pairing is tested the same way: a completed frame in hold, with new traffic arriving before release. Here the bench expects no acknowledge, an unchanged buffer and no extra interrupt.

// File: rtl/cec_rx_pkg.sv
package cec_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START_LO, S_START_HI, S_BIT_LO, S_BIT_HI, S_HOLD
  } rx_state_t;

  localparam logic [3:0] BCAST_ADDR = 4'hF;
  localparam logic [3:0] DATA_LAST  = 4'd7;
  localparam logic [3:0] EOM_SLOT   = 4'd8;
  localparam logic [3:0] ACK_SLOT   = 4'd9;

  // The destination nibble claims this receiver only for a registered address
  function automatic logic wants_ack(input logic [3:0] dest, input logic [3:0] own);
    return (dest == own) && (own != BCAST_ADDR);
  endfunction

endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_count,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_count) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/cec_line_filter.sv
module cec_line_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic fell,
  output logic rose
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic          s1, s2, level;
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; level <= 1'b1;
      run <= '0; fell <= 1'b0; rose <= 1'b0;
    end else begin
      s1   <= line_in;
      s2   <= s1;
      fell <= 1'b0;
      rose <= 1'b0;
      if (s2 == level) begin
        run <= '0;
      end else if (run == CW'(FILT_CYC - 1)) begin
        level <= s2;
        run   <= '0;
        fell  <= !s2;
        rose  <= s2;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cec_frame_fsm.sv
module cec_frame_fsm
  import cec_rx_pkg::*;
#(
  parameter int TW    = 8,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          fell,
  input  logic          rose,
  input  logic [TW-1:0] t_sl_min,
  input  logic [TW-1:0] t_sl_max,
  input  logic [TW-1:0] t_sp_min,
  input  logic [TW-1:0] t_sp_max,
  input  logic [TW-1:0] t_one_min,
  input  logic [TW-1:0] t_one_max,
  input  logic [TW-1:0] t_zero_min,
  input  logic [TW-1:0] t_zero_max,
  input  logic [TW-1:0] t_per_min,
  input  logic [TW-1:0] t_per_max,
  input  logic [TW-1:0] t_ack,
  input  logic [3:0]    own_addr,
  input  logic          release_i,
  output logic          line_pull,
  output logic          byte_we,
  output logic [IW-1:0] byte_idx,
  output logic [7:0]    byte_val,
  output logic [IW-1:0] stored,
  output logic          eom_o,
  output logic          good_o,
  output logic          irq_o
);
  function automatic logic in_window(input logic [TW-1:0] v, input logic [TW-1:0] lo,
                                     input logic [TW-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction

  rx_state_t     st;
  logic [TW-1:0] since_fall;
  logic [3:0]    bit_idx;
  logic [7:0]    shreg;
  logic [IW-1:0] cnt;
  logic          eom_bit, ack_me;
  logic          is1, is0, lo_ok, per_ok, late, sl_ok, sp_ok, sp_late;
  logic          finish_ok, finish_bad;

  always_comb begin
    is1        = in_window(since_fall, t_one_min, t_one_max);
    is0        = in_window(since_fall, t_zero_min, t_zero_max);
    lo_ok      = is1 || is0;
    per_ok     = in_window(since_fall, t_per_min, t_per_max);
    late       = since_fall > t_per_max;
    sl_ok      = in_window(since_fall, t_sl_min, t_sl_max);
    sp_ok      = in_window(since_fall, t_sp_min, t_sp_max);
    sp_late    = since_fall > t_sp_max;
    finish_bad = ((st == S_BIT_LO) && (rose ? !lo_ok : late)) ||
                 ((st == S_BIT_HI) && (fell ? !per_ok : late));
    finish_ok  = (st == S_BIT_LO) && rose && lo_ok && (bit_idx == ACK_SLOT) && eom_bit;
    byte_val   = {shreg[6:0], is1};
    byte_we    = (st == S_BIT_LO) && rose && lo_ok && (bit_idx == DATA_LAST) &&
                 (cnt < IW'(DEPTH));
    byte_idx   = cnt;
    line_pull  = (st == S_BIT_LO) && (bit_idx == ACK_SLOT) && ack_me && (since_fall < t_ack);
    stored     = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; since_fall <= '0; bit_idx <= '0; shreg <= '0; cnt <= '0;
      eom_bit <= 1'b0; ack_me <= 1'b0; eom_o <= 1'b0; good_o <= 1'b0; irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (fell)                          since_fall <= '0;
      else if (tick && since_fall != '1) since_fall <= since_fall + 1'b1;

      if (finish_ok || finish_bad) begin
        st     <= S_HOLD;
        eom_o  <= 1'b1;
        good_o <= finish_ok;
        irq_o  <= 1'b1;
      end else begin
        case (st)
          S_IDLE:     if (fell) st <= S_START_LO;
          S_START_LO: if (rose) st <= sl_ok ? S_START_HI : S_IDLE;
          S_START_HI: begin
            if (fell) begin
              if (sp_ok) begin
                st <= S_BIT_LO; bit_idx <= '0; cnt <= '0;
                ack_me <= 1'b0; eom_bit <= 1'b0;
              end else begin
                st <= S_START_LO;
              end
            end else if (sp_late) begin
              st <= S_IDLE;
            end
          end
          S_BIT_LO: begin
            if (rose) begin
              st      <= S_BIT_HI;
              bit_idx <= (bit_idx == ACK_SLOT) ? 4'd0 : bit_idx + 4'd1;
              if (bit_idx < EOM_SLOT) shreg <= byte_val;
              if (bit_idx == DATA_LAST) begin
                if (cnt == '0) ack_me <= wants_ack(byte_val[3:0], own_addr);
                if (cnt < IW'(DEPTH)) cnt <= cnt + 1'b1;
              end
              if (bit_idx == EOM_SLOT) eom_bit <= is1;
            end
          end
          S_BIT_HI: if (fell) st <= S_BIT_LO;
          S_HOLD: begin
            if (release_i) begin
              st <= S_IDLE; eom_o <= 1'b0; good_o <= 1'b0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cec_rx_store.sv
module cec_rx_store #(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [7:0]         val,
  output logic [DEPTH*8-1:0] data_flat
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [7:0] slot;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     slot <= '0;
      else if (we && idx == IW'(g))   slot <= val;
    end
    assign data_flat[8*g +: 8] = slot;
  end
endmodule

// File: rtl/cec_frame_receiver.sv
module cec_frame_receiver
  import cec_rx_pkg::*;
#(
  parameter int DIV_W    = 12,
  parameter int TW       = 8,
  parameter int DEPTH    = 16,
  parameter int FILT_CYC = 3,
  localparam int IW      = $clog2(DEPTH + 1),
  localparam int LW      = $clog2(DEPTH),
  localparam int WORDS   = DEPTH / 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cec_in,
  output logic               line_pull,
  input  logic [DIV_W-1:0]   div_count,
  input  logic [3:0]         own_addr,
  input  logic [TW-1:0]      thr_start_lo_min,
  input  logic [TW-1:0]      thr_start_lo_max,
  input  logic [TW-1:0]      thr_start_per_min,
  input  logic [TW-1:0]      thr_start_per_max,
  input  logic [TW-1:0]      thr_one_min,
  input  logic [TW-1:0]      thr_one_max,
  input  logic [TW-1:0]      thr_zero_min,
  input  logic [TW-1:0]      thr_zero_max,
  input  logic [TW-1:0]      thr_bit_per_min,
  input  logic [TW-1:0]      thr_bit_per_max,
  input  logic [TW-1:0]      thr_ack_low,
  input  logic               rx_release,
  output logic               rx_eom,
  output logic               rx_good,
  output logic               rx_irq,
  output logic [LW-1:0]      rx_len_m1,
  output logic [WORDS*32-1:0] rx_words
);
  function automatic logic [LW-1:0] len_field(input logic [IW-1:0] n);
    return (n == '0) ? '0 : LW'(n - 1'b1);
  endfunction

  logic          tick_w, fell_w, rose_w, byte_we_w;
  logic [IW-1:0] byte_idx_w, stored_w;
  logic [7:0]    byte_val_w;

  cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_count(div_count), .tick(tick_w));

  cec_line_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk(clk), .rst_n(rst_n), .line_in(cec_in), .fell(fell_w), .rose(rose_w));

  cec_frame_fsm #(.TW(TW), .DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .fell(fell_w), .rose(rose_w),
    .t_sl_min(thr_start_lo_min), .t_sl_max(thr_start_lo_max),
    .t_sp_min(thr_start_per_min), .t_sp_max(thr_start_per_max),
    .t_one_min(thr_one_min), .t_one_max(thr_one_max),
    .t_zero_min(thr_zero_min), .t_zero_max(thr_zero_max),
    .t_per_min(thr_bit_per_min), .t_per_max(thr_bit_per_max),
    .t_ack(thr_ack_low), .own_addr(own_addr), .release_i(rx_release),
    .line_pull(line_pull), .byte_we(byte_we_w), .byte_idx(byte_idx_w),
    .byte_val(byte_val_w), .stored(stored_w),
    .eom_o(rx_eom), .good_o(rx_good), .irq_o(rx_irq));

  cec_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(byte_we_w), .idx(byte_idx_w), .val(byte_val_w),
    .data_flat(rx_words));

  assign rx_len_m1 = len_field(stored_w);
endmodule

// File: rtl/cec_frame_receiver_chk.sv
module cec_frame_receiver_chk #(
  parameter int DIV_W = 12,
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [DIV_W-1:0] div_count,
  input logic [3:0]       own_addr,
  input logic             rx_irq,
  input logic             rx_eom,
  input logic             rx_good,
  input logic             rx_release,
  input logic             line_pull,
  input logic             byte_we,
  input logic [IW-1:0]    byte_idx
);
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_count != '0) |=> !tick);

  assert_irq_with_eom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_eom);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);

  assert_good_implies_eom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_good |-> rx_eom);

  assert_hold_until_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_eom && !rx_release) |=> rx_eom);

  assert_no_pull_in_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eom |-> !line_pull);

  assert_no_ack_unregistered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (own_addr == 4'hF) |-> !line_pull);

  assert_store_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> (byte_idx < IW'(DEPTH)));
endmodule

bind cec_frame_receiver cec_frame_receiver_chk #(.DIV_W(DIV_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .div_count(div_count), .own_addr(own_addr),
  .rx_irq(rx_irq), .rx_eom(rx_eom), .rx_good(rx_good), .rx_release(rx_release),
  .line_pull(line_pull), .byte_we(byte_we_w), .byte_idx(byte_idx_w));

// File: tb/cec_frame_receiver_tb_top.sv
module cec_frame_receiver_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, drv_low, line_pull, rx_release;
  logic [11:0]  div_count;
  logic [3:0]   own_addr;
  logic         rx_eom, rx_good, rx_irq;
  logic [3:0]   rx_len_m1;
  logic [127:0] rx_words;
  wire          cec_line = !(drv_low || line_pull);

  int checks = 0, errors = 0, irq_seen = 0, div_v = 1;
  bit finished = 1'b0;
  logic [7:0] fbuf [0:19];

  cec_frame_receiver dut_i (
    .clk(clk), .rst_n(rst_n), .cec_in(cec_line), .line_pull(line_pull),
    .div_count(div_count), .own_addr(own_addr),
    .thr_start_lo_min(8'd35), .thr_start_lo_max(8'd39),
    .thr_start_per_min(8'd43), .thr_start_per_max(8'd47),
    .thr_one_min(8'd4), .thr_one_max(8'd8),
    .thr_zero_min(8'd13), .thr_zero_max(8'd17),
    .thr_bit_per_min(8'd20), .thr_bit_per_max(8'd28),
    .thr_ack_low(8'd15), .rx_release(rx_release),
    .rx_eom(rx_eom), .rx_good(rx_good), .rx_irq(rx_irq),
    .rx_len_m1(rx_len_m1), .rx_words(rx_words));

  always @(posedge clk) if (rst_n && rx_irq) irq_seen++;

  task automatic ticks(input int n);
    repeat (n * (div_v + 1)) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic raw_bit(input int low_t, input int per_t, input bit glitch);
    drv_low = 1'b1; ticks(low_t); drv_low = 1'b0;
    if (glitch) begin
      ticks(3); drv_low = 1'b1; @(negedge clk); drv_low = 1'b0;
      ticks(per_t - low_t - 3);
    end else begin
      ticks(per_t - low_t);
    end
  endtask

  task automatic data_bit(input bit b, input bit glitch);
    raw_bit(b ? 6 : 15, 24, glitch);
  endtask

  // ack slot is sent as a short 1; the pull state is sampled 10 ticks into it
  task automatic send_frame(input int n, input bit exp_ack, input bit glitch, input string tag);
    raw_bit(37, 45, 1'b0);
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) data_bit(fbuf[i][k], glitch);
      data_bit(i == n - 1, glitch);
      drv_low = 1'b1; ticks(6); drv_low = 1'b0; ticks(4);
      chk(tag, "ack pull", line_pull, exp_ack);
      ticks(14);
    end
    ticks(4);
  endtask

  task automatic chk_frame(input int n, input int irq_before);
    logic [127:0] exp_w, mask;
    int m;
    m = (n > 16) ? 16 : n;
    exp_w = '0; mask = '0;
    for (int j = 0; j < m; j++) begin
      exp_w[8*j +: 8] = fbuf[j];
      mask[8*j +: 8]  = 8'hFF;
    end
    chk("R6", "eom", rx_eom, 1);
    chk("R6", "good", rx_good, 1);
    chk("R6", "irq count", irq_seen - irq_before, 1);
    chk("R5", "len", rx_len_m1, m - 1);
    chk("R4", "data", rx_words & mask, exp_w);
  endtask

  task automatic do_release();
    @(negedge clk); rx_release = 1'b1;
    @(negedge clk); rx_release = 1'b0;
    @(negedge clk);
    chk("R8", "eom after release", rx_eom, 0);
    chk("R8", "good after release", rx_good, 0);
  endtask

  task automatic do_reset(input int dv);
    rst_n = 1'b0; div_v = dv; div_count = 12'(dv);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    ticks(4);
  endtask

  initial begin
    int base;
    logic [127:0] keep;
    drv_low = 1'b0; rx_release = 1'b0; own_addr = 4'd4;
    do_reset(1);

    chk("R8", "reset eom", rx_eom, 0);
    chk("R8", "reset good", rx_good, 0);
    chk("R8", "reset pull", line_pull, 0);
    chk("R5", "reset len", rx_len_m1, 0);
    chk("R4", "reset data", rx_words, 0);

    // own-addressed frame
    fbuf[0] = 8'h14; fbuf[1] = 8'h36; fbuf[2] = 8'hA5;
    base = irq_seen;
    send_frame(3, 1'b1, 1'b0, "R9");
    chk_frame(3, base);
    do_release();

    // bit order
    fbuf[0] = 8'h14; fbuf[1] = 8'h80; fbuf[2] = 8'h01;
    base = irq_seen;
    send_frame(3, 1'b1, 1'b0, "R9");
    chk("R3", "msb first", rx_words[23:8], 16'h0180);
    chk_frame(3, base);
    do_release();

    // broadcast, other destination, unregistered
    fbuf[0] = 8'h1F; fbuf[1] = 8'h82; fbuf[2] = 8'h10; fbuf[3] = 8'h00;
    base = irq_seen;
    send_frame(4, 1'b0, 1'b0, "R10");
    chk_frame(4, base);
    do_release();
    fbuf[0] = 8'h17; fbuf[1] = 8'h5A;
    base = irq_seen;
    send_frame(2, 1'b0, 1'b0, "R10");
    chk_frame(2, base);
    do_release();
    own_addr = 4'hF;
    fbuf[0] = 8'h3F; fbuf[1] = 8'hC0;
    base = irq_seen;
    send_frame(2, 1'b0, 1'b0, "R10");
    chk_frame(2, base);
    do_release();
    own_addr = 4'd4;

    // over-long frame
    fbuf[0] = 8'h14;
    for (int i = 1; i < 18; i++) fbuf[i] = 8'(i * 37 + 5);
    base = irq_seen;
    send_frame(18, 1'b1, 1'b0, "R11");
    chk_frame(18, base);
    chk("R11", "len saturated", rx_len_m1, 15);

    // traffic during hold is ignored
    keep = rx_words;
    fbuf[0] = 8'h14; fbuf[1] = 8'h99;
    base = irq_seen;
    send_frame(2, 1'b0, 1'b0, "R8");
    chk("R8", "hold data", rx_words, keep);
    chk("R8", "hold irq", irq_seen - base, 0);
    chk("R8", "hold eom", rx_eom, 1);
    do_release();

    // stray pulses on an idle line
    base = irq_seen;
    raw_bit(20, 45, 1'b0);
    ticks(20);
    raw_bit(37, 60, 1'b0);
    ticks(20);
    chk("R2", "stray eom", rx_eom, 0);
    chk("R2", "stray irq", irq_seen - base, 0);
    fbuf[0] = 8'h14; fbuf[1] = 8'h55;
    send_frame(2, 1'b1, 1'b0, "R2");
    chk_frame(2, base);
    do_release();

    // abort on a low time between windows
    base = irq_seen;
    raw_bit(37, 45, 1'b0);
    data_bit(1'b0, 1'b0); data_bit(1'b1, 1'b0); data_bit(1'b0, 1'b0);
    raw_bit(10, 24, 1'b0);
    ticks(30);
    chk("R7", "abort low eom", rx_eom, 1);
    chk("R7", "abort low good", rx_good, 0);
    chk("R7", "abort low irq", irq_seen - base, 1);
    do_release();

    // abort on a stretched period
    base = irq_seen;
    raw_bit(37, 45, 1'b0);
    data_bit(1'b1, 1'b0);
    raw_bit(6, 34, 1'b0);
    ticks(10);
    chk("R7", "abort period eom", rx_eom, 1);
    chk("R7", "abort period good", rx_good, 0);
    chk("R7", "abort period irq", irq_seen - base, 1);
    do_release();

    // glitches in every high phase
    fbuf[0] = 8'h14; fbuf[1] = 8'hC3; fbuf[2] = 8'h3C;
    base = irq_seen;
    send_frame(3, 1'b1, 1'b1, "R12");
    chk("R12", "glitch good", rx_good, 1);
    chk_frame(3, base);
    do_release();

    // slower tick
    do_reset(2);
    fbuf[0] = 8'h14; fbuf[1] = 8'h6B; fbuf[2] = 8'hE2; fbuf[3] = 8'h7F;
    base = irq_seen;
    send_frame(4, 1'b1, 1'b0, "R1");
    chk("R1", "divided tick frame good", rx_good, 1);
    chk_frame(4, base);
    do_release();

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule